// File: doc/BRIEF.md
# Camera Receiver Control Register Bank

This block holds the software-visible control and status state of a serial camera-interface receiver. Software reaches it over a plain 32-bit register bus. A write is one cycle with `bus_wr` high. A read is combinational from `bus_addr`.

Configuration fields are written into a pending set. The receiver datapath uses only an active copy of that set. A one-shot shadow-update command loads the pending set into the active copy, so a format, geometry or lane change takes effect as one atomic step between frames.

Hardware event pulses latch into an interrupt-source register, which software clears by writing ones to it. A masked OR of that register drives one interrupt line. The block also produces the PHY lane-enable vector. That vector covers the clock lane plus the active number of data lanes, and it is live only while the receiver is enabled.

Top module: `cam_rx_regbank`

## Requirements
- R1: After reset, and one cycle after a control write with the soft-reset bit (bit 4) set, every register reads 0 and `lane_en`, `irq`, `rx_enable` and every `act_*` output are 0.
- R2: Writes to the settle value, alignment, wrapper-clock select, data-type code, lane count and resolution change only the pending copy, which read-back returns. The `act_*` outputs take the pending values one cycle after a control write with the shadow-update bit (bit 16) set, and at no other time.
- R3: When control bit 0 (enable) is 1, `lane_en` has its low N+1 bits set, where N is the active lane-count field plus one. Bit 0 is the clock lane. When enable is 0, `lane_en` is all zero. Enable and P/N swap (bit 31) act at once, with no shadow update.
- R4: The data-type code in configuration bits 7:2 accepts only 0x1E, 0x2A, 0x2B, 0x2C and 0x30 to 0x33. A write that carries any other code leaves the stored code unchanged but still updates the lane count in bits 1:0.
- R5: A high bit of `evt_in` sets the matching interrupt-source bit (offset 0x14) at the next edge, for the implemented bits 0xF000F03F only. The other source bits always read 0.
- R6: Writing ones to the source register clears those bits. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: The mask register (offset 0x10) stores only the bits 0xF000103F. Mask bit 12 enables all four start-of-transmission source bits 15:12. `irq` is 1 exactly while some source bit is set and enabled.
- R8: The soft-reset and shadow-update bits always read back as 0. Reads from offsets other than 0x00, 0x04, 0x08, 0x10, 0x14 and 0x2C return 0.
- R9: Field positions are as follows. Control: wrapper-clock select at bit 8, 32-bit alignment at bit 20. PHY control (0x04): settle in bits 31:27, with bits 4:0 reading `lane_en`. Configuration (0x08): lane count minus one in bits 1:0. Resolution (0x2C): width in bits 31:16, height in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_in | input | 32 | Event pulses, one per source bit |
| irq | output | 1 | Interrupt request |
| lane_en | output | LANES_MAX+1 | PHY lane enables, bit 0 is the clock lane |
| rx_enable | output | 1 | Receiver enable |
| pn_swap | output | 1 | Differential pair polarity swap |
| act_align32 | output | 1 | Active 32-bit data alignment |
| act_wclk_ext | output | 1 | Active wrapper-clock select |
| act_fmt | output | 6 | Active data-type code |
| act_lanes_m1 | output | 2 | Active data-lane count minus one |
| act_settle | output | 5 | Active HS-RX settle value |
| act_width | output | 16 | Active frame width |
| act_height | output | 16 | Active frame height |

## Verification
Each result is due a fixed number of edges after its stimulus. A register write shows on read-back, on `rx_enable` and on `pn_swap` after one edge. Shadow update and soft reset act after two edges: one to capture the command and one to apply it. An event sets its source bit after one edge, and `irq` follows in the same cycle. The bench drives every stimulus on the falling edge and samples results on later falling edges. It checks each two-edge result once after the first edge, where it must still show the old value, and again after the second.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;
   localparam int unsigned REG_W = 32;

   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_PHY  = 8'h04;
   localparam logic [7:0] OFF_CFG  = 8'h08;
   localparam logic [7:0] OFF_MASK = 8'h10;
   localparam logic [7:0] OFF_SRC  = 8'h14;
   localparam logic [7:0] OFF_RES  = 8'h2C;

   localparam int unsigned CB_EN    = 0;
   localparam int unsigned CB_SRST  = 4;
   localparam int unsigned CB_WCLK  = 8;
   localparam int unsigned CB_UPD   = 16;
   localparam int unsigned CB_ALIGN = 20;
   localparam int unsigned CB_SWAP  = 31;

   localparam logic [REG_W-1:0] SRC_IMPL  = 32'hF000_F03F;
   localparam logic [REG_W-1:0] MASK_IMPL = 32'hF000_103F;
   localparam int unsigned SOT_LO = 12;
   localparam int unsigned SOT_N  = 4;

   typedef struct packed {
      logic [5:0]  fmt;
      logic [1:0]  lanes_m1;
      logic [15:0] width;
      logic [15:0] height;
      logic [4:0]  settle;
      logic        align32;
      logic        wclk_ext;
   } cfg_t;

   function automatic logic fmt_ok(input logic [5:0] c);
      return (c == 6'h1E) || (c >= 6'h2A && c <= 6'h2C) || (c >= 6'h30 && c <= 6'h33);
   endfunction
endpackage

// File: rtl/cam_rx_irq.sv
module cam_rx_irq
   import cam_rx_pkg::*;
#(
   parameter int unsigned W = REG_W
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         src_wr,
   input  logic         mask_wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] src_q,
   output logic [W-1:0] mask_q,
   output logic         irq
);
   if (W != 32) begin : g_bad_w
      $error("cam_rx_irq: W must be 32");
   end

   logic [W-1:0] clr;
   logic [W-1:0] mask_exp;

   assign clr = src_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
      end else if (srst) begin
         src_q  <= '0;
         mask_q <= '0;
      end else begin
         src_q <= ((src_q & ~clr) | evt) & SRC_IMPL;
         if (mask_wr) mask_q <= wdata & MASK_IMPL;
      end
   end

   always_comb begin
      mask_exp = mask_q;
      mask_exp[SOT_LO +: SOT_N] = {SOT_N{mask_q[SOT_LO]}};
   end

   assign irq = |(src_q & mask_exp);
endmodule

// File: rtl/cam_rx_shadow.sv
module cam_rx_shadow
   import cam_rx_pkg::*;
#(
   parameter bit SHADOW_EN = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic upd,
   input  cfg_t pend,
   output cfg_t act
);
   if (SHADOW_EN) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    act <= '0;
         else if (srst) act <= '0;
         else if (upd)  act <= pend;
      end
   end else begin : g_bypass
      assign act = pend;
   end
endmodule

// File: rtl/cam_rx_lane_map.sv
module cam_rx_lane_map #(
   parameter int unsigned LANES_MAX = 4,
   localparam int unsigned LANE_W = LANES_MAX + 1
)(
   input  logic              en,
   input  logic [1:0]        lanes_m1,
   output logic [LANE_W-1:0] lane_en
);
   if (LANES_MAX < 1 || LANES_MAX > 4) begin : g_bad_lanes
      $error("cam_rx_lane_map: LANES_MAX must be 1..4");
   end

   logic [2:0] n_data;
   assign n_data = {1'b0, lanes_m1} + 3'd1;

   assign lane_en[0] = en;
   for (genvar i = 1; i < LANE_W; i++) begin : g_lane
      assign lane_en[i] = en && (n_data >= 3'(i));
   end
endmodule

// File: rtl/cam_rx_regbank.sv
module cam_rx_regbank
   import cam_rx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned LANES_MAX = 4,
   parameter bit          SHADOW_EN = 1'b1,
   localparam int unsigned LANE_W   = LANES_MAX + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       evt_in,
   output logic              irq,
   output logic [LANE_W-1:0] lane_en,
   output logic              rx_enable,
   output logic              pn_swap,
   output logic              act_align32,
   output logic              act_wclk_ext,
   output logic [5:0]        act_fmt,
   output logic [1:0]        act_lanes_m1,
   output logic [4:0]        act_settle,
   output logic [15:0]       act_width,
   output logic [15:0]       act_height
);
   if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
      $error("cam_rx_regbank: ADDR_W must be 6..8");
   end

   logic wr_ctrl, wr_phy, wr_cfg, wr_mask, wr_src, wr_res;
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_phy  = bus_wr && (bus_addr == ADDR_W'(OFF_PHY));
   assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
   assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
   assign wr_src  = bus_wr && (bus_addr == ADDR_W'(OFF_SRC));
   assign wr_res  = bus_wr && (bus_addr == ADDR_W'(OFF_RES));

   logic en_q, swap_q, srst_q, upd_q;
   cfg_t pend, act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; swap_q <= 1'b0; srst_q <= 1'b0; upd_q <= 1'b0;
         pend <= '0;
      end else if (srst_q) begin
         en_q <= 1'b0; swap_q <= 1'b0; srst_q <= 1'b0; upd_q <= 1'b0;
         pend <= '0;
      end else begin
         srst_q <= wr_ctrl && bus_wdata[CB_SRST];
         upd_q  <= wr_ctrl && bus_wdata[CB_UPD];
         if (wr_ctrl) begin
            en_q          <= bus_wdata[CB_EN];
            swap_q        <= bus_wdata[CB_SWAP];
            pend.wclk_ext <= bus_wdata[CB_WCLK];
            pend.align32  <= bus_wdata[CB_ALIGN];
         end
         if (wr_phy) pend.settle <= bus_wdata[31:27];
         if (wr_cfg) begin
            pend.lanes_m1 <= bus_wdata[1:0];
            if (fmt_ok(bus_wdata[7:2])) pend.fmt <= bus_wdata[7:2];
         end
         if (wr_res) begin
            pend.width  <= bus_wdata[31:16];
            pend.height <= bus_wdata[15:0];
         end
      end
   end

   logic [31:0] src_q, mask_q;

   cam_rx_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst_q),
      .src_wr  (wr_src),
      .mask_wr (wr_mask),
      .wdata   (bus_wdata),
      .evt     (evt_in),
      .src_q   (src_q),
      .mask_q  (mask_q),
      .irq     (irq)
   );

   cam_rx_shadow #(.SHADOW_EN(SHADOW_EN)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst_q),
      .upd   (upd_q),
      .pend  (pend),
      .act   (act)
   );

   cam_rx_lane_map #(.LANES_MAX(LANES_MAX)) u_lanes (
      .en       (en_q),
      .lanes_m1 (act.lanes_m1),
      .lane_en  (lane_en)
   );

   always_comb begin
      bus_rdata = '0;
      case (8'(bus_addr))
         OFF_CTRL: begin
            bus_rdata[CB_EN]    = en_q;
            bus_rdata[CB_WCLK]  = pend.wclk_ext;
            bus_rdata[CB_ALIGN] = pend.align32;
            bus_rdata[CB_SWAP]  = swap_q;
         end
         OFF_PHY: begin
            bus_rdata[31:27] = pend.settle;
            bus_rdata[4:0]   = 5'(lane_en);
         end
         OFF_CFG: begin
            bus_rdata[1:0] = pend.lanes_m1;
            bus_rdata[7:2] = pend.fmt;
         end
         OFF_MASK: bus_rdata = mask_q;
         OFF_SRC:  bus_rdata = src_q;
         OFF_RES:  bus_rdata = {pend.width, pend.height};
         default:  bus_rdata = '0;
      endcase
   end

   assign rx_enable    = en_q;
   assign pn_swap      = swap_q;
   assign act_align32  = act.align32;
   assign act_wclk_ext = act.wclk_ext;
   assign act_fmt      = act.fmt;
   assign act_lanes_m1 = act.lanes_m1;
   assign act_settle   = act.settle;
   assign act_width    = act.width;
   assign act_height   = act.height;
endmodule

// File: rtl/cam_rx_regbank_chk.sv
module cam_rx_regbank_chk
   import cam_rx_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [31:0]       evt_in,
   input logic              irq,
   input logic [LANE_W-1:0] lane_en,
   input logic              rx_enable,
   input logic              upd_q,
   input logic              srst_q,
   input logic [31:0]       src_q,
   input logic [31:0]       mask_q,
   input cfg_t              act
);
   logic [LANE_W-1:0] lane_nxt;
   assign lane_nxt = lane_en + LANE_W'(1);

   // R3: no lane is driven while the receiver is off
   a_r3_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |-> (lane_en == '0));

   // R3: enabled lanes form a contiguous run starting at the clock lane
   a_r3_lanes_contig: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable |-> (lane_en[0] && $onehot0(lane_nxt)));

   // R2: the active set moves only after a shadow update or soft reset
   a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_q && !srst_q) |=> $stable(act));

   // R5: an implemented event bit is latched at the next edge
   a_r5_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst_q && ((evt_in & SRC_IMPL) != '0))
      |=> ((src_q & $past(evt_in & SRC_IMPL)) == $past(evt_in & SRC_IMPL)));

   // R7: no interrupt without a pending source and an enabling mask bit
   a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((src_q != '0) && (mask_q != '0)));

   // R8: one-shot command bits never read back as 1
   a_r8_oneshot_read0: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFF_CTRL)) |-> (!bus_rdata[CB_SRST] && !bus_rdata[CB_UPD]));
endmodule

bind cam_rx_regbank cam_rx_regbank_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .evt_in    (evt_in),
   .irq       (irq),
   .lane_en   (lane_en),
   .rx_enable (rx_enable),
   .upd_q     (upd_q),
   .srst_q    (srst_q),
   .src_q     (src_q),
   .mask_q    (mask_q),
   .act       (act)
);

// File: tb/cam_rx_regbank_tb.sv
module cam_rx_regbank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_in = '0;
   logic        irq;
   logic [4:0]  lane_en;
   logic        rx_enable, pn_swap, act_align32, act_wclk_ext;
   logic [5:0]  act_fmt;
   logic [1:0]  act_lanes_m1;
   logic [4:0]  act_settle;
   logic [15:0] act_width, act_height;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   cam_rx_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq),
      .lane_en(lane_en), .rx_enable(rx_enable), .pn_swap(pn_swap),
      .act_align32(act_align32), .act_wclk_ext(act_wclk_ext), .act_fmt(act_fmt),
      .act_lanes_m1(act_lanes_m1), .act_settle(act_settle),
      .act_width(act_width), .act_height(act_height)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<=100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [31:0] e);
      @(negedge clk);
      evt_in = e;
      @(negedge clk);
      evt_in = '0;
   endtask

   function automatic logic fmt_valid(input int c);
      return c == 'h1E || c == 'h2A || c == 'h2B || c == 'h2C || (c >= 'h30 && c <= 'h33);
   endfunction

   logic [31:0] d;
   logic [7:0]  offs [6] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h2C};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 6; i++) begin
         rd(offs[i], d);
         chk("R1 reset read", d, 0);
      end
      chk("R1 reset lane_en/irq", {27'b0, lane_en}, {31'b0, irq});

      // R2/R3/R9 lane count sweep with shadow update
      for (int l = 0; l < 4; l++) begin
         wr(8'h08, {24'b0, 6'h1E, 2'(l)});
         wr(8'h2C, {16'(100 + l), 16'(50 + l)});
         wr(8'h04, {5'(l + 3), 27'b0});
         rd(8'h08, d);
         chk("R9 config readback", d, {24'b0, 6'h1E, 2'(l)});
         rd(8'h04, d);
         chk("R9 phy settle readback", d[31:27], 5'(l + 3));
         chk("R2 active held before update", {30'b0, act_lanes_m1}, (l == 0) ? 0 : 32'(l - 1));
         wr(8'h00, 32'h0011_0101);
         chk("R3 enable immediate", {31'b0, rx_enable}, 1);
         chk("R2 active not yet loaded", {16'b0, act_width}, (l == 0) ? 0 : 32'(99 + l));
         @(negedge clk);
         chk("R2 active lanes", {30'b0, act_lanes_m1}, l);
         chk("R2 active geometry", {act_width, act_height}, {16'(100 + l), 16'(50 + l)});
         chk("R2 active settle/fmt", {21'b0, act_settle, act_fmt}, {21'b0, 5'(l + 3), 6'h1E});
         chk("R2 align/wclk", {30'b0, act_align32, act_wclk_ext}, 3);
         chk("R3 lane enable", {27'b0, lane_en}, (1 << (l + 2)) - 1);
         rd(8'h04, d);
         chk("R9 phy lane readback", d[4:0], (1 << (l + 2)) - 1);
      end
      wr(8'h00, 32'h8000_0000);
      chk("R3 disabled lanes", {27'b0, lane_en}, 0);
      chk("R3 swap immediate", {31'b0, pn_swap}, 1);
      rd(8'h00, d);
      chk("R9 ctrl readback", d, 32'h8000_0000);

      // R4 data-type code sweep
      for (int c = 0; c < 64; c++) begin
         wr(8'h08, {24'b0, 6'h2A, 2'd1});
         wr(8'h08, {24'b0, 6'(c), 2'd2});
         rd(8'h08, d);
         chk("R4 code filter", d, {24'b0, fmt_valid(c) ? 6'(c) : 6'h2A, 2'd2});
      end

      // R5/R6/R7 per-bit sweep
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d);
      chk("R7 mask implemented", d, 32'hF000_103F);
      for (int i = 0; i < 32; i++) begin
         logic impl;
         impl = (32'hF000_F03F >> i) & 1;
         wr(8'h10, 32'h0);
         wr(8'h14, 32'hFFFF_FFFF);
         pulse(32'(1) << i);
         rd(8'h14, d);
         chk("R5 event latch", d, impl ? (32'(1) << i) : 0);
         chk("R7 masked off no irq", {31'b0, irq}, 0);
         wr(8'h10, 32'hFFFF_FFFF);
         chk("R7 irq when enabled", {31'b0, irq}, {31'b0, impl});
         wr(8'h14, 32'(1) << i);
         rd(8'h14, d);
         chk("R6 write-one clear", d, 0);
      end

      // R6 event beats clear in the same cycle
      wr(8'h14, 32'hFFFF_FFFF);
      pulse(32'h0000_0006);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h0000_0006; evt_in = 32'h0000_0002;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = '0;
      rd(8'h14, d);
      chk("R6 event wins over clear", d, 32'h0000_0002);

      // R7 shared start-of-transmission mask bit
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h10, 32'h0000_1000);
      pulse(32'h0000_4000);
      chk("R7 SOT bit 14 via mask 12", {31'b0, irq}, 1);
      wr(8'h10, 32'h0000_0FFF);
      chk("R7 SOT masked", {31'b0, irq}, 0);

      // R8 one-shot bits and unmapped offsets
      wr(8'h00, 32'h0001_0001);
      rd(8'h00, d);
      chk("R8 shadow bit reads 0", d, 32'h0000_0001);
      rd(8'h0C, d); chk("R8 unmapped 0x0C", d, 0);
      rd(8'h18, d); chk("R8 unmapped 0x18", d, 0);
      rd(8'h30, d); chk("R8 unmapped 0x30", d, 0);
      rd(8'hFC, d); chk("R8 unmapped 0xFC", d, 0);

      // R1 soft reset
      wr(8'h10, 32'hFFFF_FFFF);
      pulse(32'h0000_0001);
      wr(8'h00, 32'h0000_0011);
      chk("R1 soft reset pending", {31'b0, rx_enable}, 1);
      @(negedge clk);
      chk("R1 soft reset outputs", {irq, rx_enable, lane_en, act_fmt, act_lanes_m1}, 0);
      chk("R1 soft reset active", {act_width, act_height}, 0);
      for (int i = 0; i < 6; i++) begin
         rd(offs[i], d);
         chk("R1 soft reset read", d, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule